// File: doc/BRIEF.md
# UART Hardware Autoflow Controller

This block handles hardware flow control for a UART that has FIFOs. It decides when the transmitter may take the next character from its FIFO, based on the far end's clear-to-send line. It also drives the request-to-send line from the receive FIFO fill level, so the far end pauses before the local receive FIFO overflows. The baud generator, shift registers and FIFO storage sit outside the block. It sees only their status: receive level, transmitter idle and transmit-data-pending.

Automatic control applies only when two conditions hold together: the enable bit is set and the UART is in FIFO mode. Otherwise request-to-send follows the software bit and clear-to-send has no effect on transmission. In automatic mode, the block also masks the interrupt that a clear-to-send change would raise. The incoming clear-to-send pin is synchronised before use. A start of transmission is allowed only at a character boundary, so a character already on the line always finishes.

Top module: `afc_ctrl`

## Requirements
- R1: Automatic mode is active only when `afc_en` and `fifo_mode` are both 1. Outside it, `rts_n` equals the inverse of (`sw_rts` AND NOT `loop_mode`), and the level of `cts_n` has no effect on `tx_permit`.
- R2: In automatic mode, `tx_permit` is 0 whenever the synchronised `cts_n` is 1 (inactive). No character is released while the far end refuses data.
- R3: In automatic mode, with `sw_rts`=1 and `loop_mode`=0, `rts_n` is 0 (active) while `rx_level` is below the effective threshold, and 1 once `rx_level` reaches or exceeds it.
- R4: `sw_rts`=0, `loop_mode`=1 or an active reset (`rst_n`=0) each force `rts_n` to 1, in any mode.
- R5: `cts_irq_mask` is 1 exactly when automatic mode is active, and 0 otherwise.
- R6: The effective threshold is `trig_level` clamped to the range 1 to the selected depth. The selected depth is 16 when `deep_mode`=0 and 64 when `deep_mode`=1. A trigger of 0 is therefore treated as 1, and a trigger above the depth is treated as the depth.
- R7: `tx_permit` is 1 only while `tx_idle`=1 and `tx_req`=1. A character in progress (`tx_idle`=0) is never interrupted, and the stall takes effect at the next start-bit boundary.
- R8: `cts_n` passes through a two-flop synchronizer that resets to inactive. A change on `cts_n` reaches `tx_permit` after exactly two rising clock edges.
- R9: `rts_n` is registered and reflects its inputs one rising edge later. It returns to 0 on the first edge after `rx_level` drops below the threshold, with no hysteresis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| afc_en | input | 1 | Automatic flow control enable bit |
| fifo_mode | input | 1 | FIFOs enabled |
| sw_rts | input | 1 | Software request-to-send bit |
| loop_mode | input | 1 | Internal loopback active |
| deep_mode | input | 1 | 1 selects 64-entry FIFO, 0 selects 16-entry |
| trig_level | input | 7 | Programmed receive threshold |
| rx_level | input | 7 | Current receive FIFO occupancy |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_idle | input | 1 | Transmitter at a character boundary |
| tx_req | input | 1 | Transmit FIFO holds a character |
| tx_permit | output | 1 | Pop strobe for the transmit FIFO |
| rts_n | output | 1 | Request-to-send pin, active low |
| cts_irq_mask | output | 1 | Suppresses the clear-to-send change interrupt |

## Verification
The assertions take several things for granted about the inputs:
- `rx_level` never exceeds the selected depth by more than the counter width allows.
- `tx_idle` and `tx_req` come from synchronous logic in the same clock domain.
- Mode bits change only at clock edges.

The bench honours these by driving every input on the falling edge, keeping levels within 0 to 64, and treating `cts_n` as the only asynchronous input. It then sets `cts_n` only on falling edges, so the two-edge synchronizer latency can be counted exactly.

// File: rtl/afc_pkg.sv
package afc_pkg;

   typedef enum logic {
      AFC_MODE_MANUAL = 1'b0,
      AFC_MODE_AUTO   = 1'b1
   } afc_mode_e;

   localparam logic CTS_INACTIVE = 1'b1;
   localparam logic RTS_INACTIVE = 1'b1;

endpackage

// File: rtl/afc_cts_sync.sv
module afc_cts_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   logic [STAGES-1:0] stage_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RESET_VAL;
            else        stage_q[i] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RESET_VAL;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/afc_tx_gate.sv
module afc_tx_gate (
   input  logic auto_on,
   input  logic cts_sync_n,
   input  logic tx_idle,
   input  logic tx_req,
   output logic tx_permit
);

   logic far_end_ready;

   // In manual mode the far end's line is disregarded.
   always_comb begin
      far_end_ready = !auto_on || (cts_sync_n == 1'b0);
      // Release only at a character boundary, never mid-character.
      tx_permit     = tx_idle && tx_req && far_end_ready;
   end

endmodule

// File: rtl/afc_rts_ctrl.sv
module afc_rts_ctrl
   import afc_pkg::*;
#(
   parameter int MAX_DEPTH     = 64,
   parameter int SHALLOW_DEPTH = 16,
   parameter int LVL_W         = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_on,
   input  logic             sw_rts,
   input  logic             loop_mode,
   input  logic             deep_mode,
   input  logic [LVL_W-1:0] trig_level,
   input  logic [LVL_W-1:0] rx_level,
   output logic             rts_n
);

   localparam logic [LVL_W-1:0] DEEP_LIM    = LVL_W'(MAX_DEPTH);
   localparam logic [LVL_W-1:0] SHALLOW_LIM = LVL_W'(SHALLOW_DEPTH);
   localparam logic [LVL_W-1:0] MIN_TRIG    = LVL_W'(1);

   logic [LVL_W-1:0] depth_lim;
   logic [LVL_W-1:0] eff_trig;
   logic             below_trig;
   logic             rts_want;
   logic             rts_n_q;

   if (SHALLOW_DEPTH == MAX_DEPTH) begin : g_fixed_depth
      logic unused_deep;
      assign unused_deep = deep_mode;
      assign depth_lim   = DEEP_LIM;
   end else begin : g_sel_depth
      assign depth_lim = deep_mode ? DEEP_LIM : SHALLOW_LIM;
   end

   always_comb begin
      if (trig_level == '0)            eff_trig = MIN_TRIG;
      else if (trig_level > depth_lim) eff_trig = depth_lim;
      else                             eff_trig = trig_level;
      below_trig = (rx_level < eff_trig);
      rts_want   = sw_rts && !loop_mode && (!auto_on || below_trig);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rts_n_q <= RTS_INACTIVE;
      else        rts_n_q <= !rts_want;
   end

   assign rts_n = rts_n_q;

endmodule

// File: rtl/afc_ctrl.sv
module afc_ctrl
   import afc_pkg::*;
#(
   parameter  int MAX_DEPTH     = 64,
   parameter  int SHALLOW_DEPTH = 16,
   parameter  int SYNC_STAGES   = 2,
   localparam int LVL_W         = $clog2(MAX_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             afc_en,
   input  logic             fifo_mode,
   input  logic             sw_rts,
   input  logic             loop_mode,
   input  logic             deep_mode,
   input  logic [LVL_W-1:0] trig_level,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             cts_n,
   input  logic             tx_idle,
   input  logic             tx_req,
   output logic             tx_permit,
   output logic             rts_n,
   output logic             cts_irq_mask
);

   if (SHALLOW_DEPTH < 1 || SHALLOW_DEPTH > MAX_DEPTH) begin : g_bad_depth
      $error("afc_ctrl: SHALLOW_DEPTH must lie in 1..MAX_DEPTH");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("afc_ctrl: SYNC_STAGES must be at least 2");
   end

   afc_mode_e mode;
   logic      auto_on;
   logic      cts_sync_n;

   assign mode         = (afc_en && fifo_mode) ? AFC_MODE_AUTO : AFC_MODE_MANUAL;
   assign auto_on      = (mode == AFC_MODE_AUTO);
   assign cts_irq_mask = auto_on;

   afc_cts_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (CTS_INACTIVE)
   ) u_cts_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (cts_n),
      .sync_out (cts_sync_n)
   );

   afc_tx_gate u_tx_gate (
      .auto_on    (auto_on),
      .cts_sync_n (cts_sync_n),
      .tx_idle    (tx_idle),
      .tx_req     (tx_req),
      .tx_permit  (tx_permit)
   );

   afc_rts_ctrl #(
      .MAX_DEPTH     (MAX_DEPTH),
      .SHALLOW_DEPTH (SHALLOW_DEPTH),
      .LVL_W         (LVL_W)
   ) u_rts_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_on    (auto_on),
      .sw_rts     (sw_rts),
      .loop_mode  (loop_mode),
      .deep_mode  (deep_mode),
      .trig_level (trig_level),
      .rx_level   (rx_level),
      .rts_n      (rts_n)
   );

endmodule

// File: rtl/afc_ctrl_chk.sv
module afc_ctrl_chk #(
   parameter int MAX_DEPTH     = 64,
   parameter int SHALLOW_DEPTH = 16,
   parameter int LVL_W         = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             afc_en,
   input logic             fifo_mode,
   input logic             sw_rts,
   input logic             loop_mode,
   input logic             deep_mode,
   input logic [LVL_W-1:0] rx_level,
   input logic             cts_n,
   input logic             tx_idle,
   input logic             tx_req,
   input logic             tx_permit,
   input logic             rts_n,
   input logic             cts_irq_mask
);

   logic [LVL_W-1:0] sel_depth;
   assign sel_depth = deep_mode ? LVL_W'(MAX_DEPTH) : LVL_W'(SHALLOW_DEPTH);

   assert_rts_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_rts || loop_mode) |=> rts_n);

   assert_permit_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_permit |-> (tx_idle && tx_req));

   assert_cts_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (afc_en && fifo_mode && tx_permit) |-> ($past(cts_n, 2) == 1'b0));

   assert_mask_manual_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!afc_en || !fifo_mode) |-> !cts_irq_mask);

   assert_rts_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (afc_en && fifo_mode && sw_rts && !loop_mode && rx_level == '0) |=> !rts_n);

   assert_rts_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (afc_en && fifo_mode && rx_level >= sel_depth) |=> rts_n);

   assert_manual_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!(afc_en && fifo_mode) && sw_rts && !loop_mode) |=> !rts_n);

endmodule

bind afc_ctrl afc_ctrl_chk #(
   .MAX_DEPTH     (MAX_DEPTH),
   .SHALLOW_DEPTH (SHALLOW_DEPTH),
   .LVL_W         (LVL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .afc_en       (afc_en),
   .fifo_mode    (fifo_mode),
   .sw_rts       (sw_rts),
   .loop_mode    (loop_mode),
   .deep_mode    (deep_mode),
   .rx_level     (rx_level),
   .cts_n        (cts_n),
   .tx_idle      (tx_idle),
   .tx_req       (tx_req),
   .tx_permit    (tx_permit),
   .rts_n        (rts_n),
   .cts_irq_mask (cts_irq_mask)
);

// File: tb/afc_ctrl_tb.sv
module afc_ctrl_tb;

   localparam int LW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          afc_en = 1'b0, fifo_mode = 1'b0, sw_rts = 1'b0, loop_mode = 1'b0;
   logic          deep_mode = 1'b0;
   logic [LW-1:0] trig_level = '0, rx_level = '0;
   logic          cts_n = 1'b1, tx_idle = 1'b0, tx_req = 1'b0;
   logic          tx_permit, rts_n, cts_irq_mask;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   afc_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .afc_en(afc_en), .fifo_mode(fifo_mode),
      .sw_rts(sw_rts), .loop_mode(loop_mode), .deep_mode(deep_mode),
      .trig_level(trig_level), .rx_level(rx_level), .cts_n(cts_n),
      .tx_idle(tx_idle), .tx_req(tx_req), .tx_permit(tx_permit),
      .rts_n(rts_n), .cts_irq_mask(cts_irq_mask)
   );

   typedef struct packed {
      logic          afc;
      logic          fm;
      logic          srts;
      logic          lp;
      logic          deep;
      logic [LW-1:0] trig;
      logic [LW-1:0] lvl;
      logic          ctsn;
      logic          idle;
      logic          req;
      logic          e_rtsn;
      logic          e_perm;
      logic          e_mask;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b1,1'b1,1'b0,1'b0,7'd8,  7'd20,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0}, // R1 en off
      '{1'b1,1'b0,1'b1,1'b0,1'b0,7'd8,  7'd20,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0}, // R1 fifo off
      '{1'b1,1'b1,1'b1,1'b0,1'b0,7'd8,  7'd3, 1'b0,1'b1,1'b1, 1'b0,1'b1,1'b1}, // R3 below
      '{1'b1,1'b1,1'b1,1'b0,1'b0,7'd8,  7'd8, 1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1}, // R3 at, R2
      '{1'b1,1'b1,1'b1,1'b0,1'b0,7'd8,  7'd7, 1'b0,1'b1,1'b1, 1'b0,1'b1,1'b1}, // R3
      '{1'b1,1'b1,1'b1,1'b0,1'b0,7'd40, 7'd16,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1}, // R6 clamp 16
      '{1'b1,1'b1,1'b1,1'b0,1'b0,7'd40, 7'd15,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b1}, // R6
      '{1'b1,1'b1,1'b1,1'b0,1'b1,7'd40, 7'd39,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b1}, // R6 deep, R2
      '{1'b1,1'b1,1'b1,1'b0,1'b1,7'd40, 7'd40,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1}, // R6
      '{1'b1,1'b1,1'b1,1'b0,1'b1,7'd100,7'd63,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b1}, // R6 clamp 64
      '{1'b1,1'b1,1'b1,1'b0,1'b1,7'd100,7'd64,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1}, // R6
      '{1'b1,1'b1,1'b1,1'b0,1'b0,7'd0,  7'd0, 1'b0,1'b1,1'b1, 1'b0,1'b1,1'b1}, // R6 zero
      '{1'b1,1'b1,1'b1,1'b0,1'b0,7'd0,  7'd1, 1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1}, // R6 zero
      '{1'b1,1'b1,1'b0,1'b0,1'b0,7'd8,  7'd0, 1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1}, // R4 sw
      '{1'b1,1'b1,1'b1,1'b1,1'b0,7'd8,  7'd0, 1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1}, // R4 loop
      '{1'b0,1'b0,1'b0,1'b0,1'b0,7'd8,  7'd0, 1'b1,1'b1,1'b1, 1'b1,1'b1,1'b0}, // R4 manual
      '{1'b1,1'b1,1'b1,1'b0,1'b0,7'd8,  7'd0, 1'b0,1'b0,1'b1, 1'b0,1'b0,1'b1}, // R7 busy
      '{1'b1,1'b1,1'b1,1'b0,1'b0,7'd8,  7'd0, 1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1}, // R7 empty
      '{1'b0,1'b1,1'b1,1'b0,1'b0,7'd8,  7'd0, 1'b1,1'b0,1'b1, 1'b0,1'b0,1'b0}  // R7 manual
   };

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      afc_en = v.afc; fifo_mode = v.fm; sw_rts = v.srts; loop_mode = v.lp;
      deep_mode = v.deep; trig_level = v.trig; rx_level = v.lvl;
      cts_n = v.ctsn; tx_idle = v.idle; tx_req = v.req;
   endtask

   task automatic edges(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // Reset state: auto on, empty FIFO, far end ready, data pending.
      afc_en = 1; fifo_mode = 1; sw_rts = 1; trig_level = 7'd8;
      rx_level = 0; cts_n = 0; tx_idle = 1; tx_req = 1;
      edges(2);
      chk("R4 rts_n in reset", rts_n, 1'b1);
      chk("R8 permit in reset (sync holds inactive)", tx_permit, 1'b0);
      chk("R5 mask in auto", cts_irq_mask, 1'b1);
      rst_n = 1;
      edges(1);
      chk("R9 rts_n one edge after reset", rts_n, 1'b0);
      chk("R8 permit after one edge", tx_permit, 1'b0);
      edges(1);
      chk("R8 permit after two edges", tx_permit, 1'b1);

      // Table walk
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         edges(3);
         chk($sformatf("vec %0d rts_n (R1 R3 R4 R6)", i), rts_n, VECS[i].e_rtsn);
         chk($sformatf("vec %0d permit (R1 R2 R7)", i), tx_permit, VECS[i].e_perm);
         chk($sformatf("vec %0d mask (R5)", i), cts_irq_mask, VECS[i].e_mask);
      end

      // CTS synchronizer latency both directions
      afc_en = 1; fifo_mode = 1; sw_rts = 1; loop_mode = 0; deep_mode = 0;
      trig_level = 7'd8; rx_level = 0; tx_idle = 1; tx_req = 1; cts_n = 1;
      edges(3);
      cts_n = 0;
      edges(1);
      chk("R8 fall after 1 edge", tx_permit, 1'b0);
      edges(1);
      chk("R8 fall after 2 edges", tx_permit, 1'b1);
      cts_n = 1;
      edges(1);
      chk("R8 rise after 1 edge", tx_permit, 1'b1);
      edges(1);
      chk("R2 rise after 2 edges", tx_permit, 1'b0);

      // Stall over a long window: count pops while far end refuses
      begin
         int pops = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (tx_permit) pops++;
         end
         checks++;
         if (pops != 0) begin
            errors++;
            $display("FAIL R2 pops while stalled actual=%0d expected=0", pops);
         end
      end

      // Manual mode: CTS level ignored
      afc_en = 0;
      edges(1);
      chk("R1 manual ignores cts", tx_permit, 1'b1);
      chk("R5 mask drops in manual", cts_irq_mask, 1'b0);
      afc_en = 1;

      // RTS reassert without hysteresis
      cts_n = 0; rx_level = 7'd8;
      edges(2);
      chk("R3 at threshold", rts_n, 1'b1);
      rx_level = 7'd7;
      edges(1);
      chk("R9 reassert one edge later", rts_n, 1'b0);
      rx_level = 7'd8;
      edges(1);
      chk("R9 deassert one edge later", rts_n, 1'b1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule